// File: doc/BRIEF.md
# Duplex Handshaked Parallel Port

This block is one 8-bit parallel port that moves bytes in both directions, each one paced by a handshake. A CPU talks to it over a one-bit address with read and write strobes. At address 0 the CPU writes the output byte or reads the input byte. At address 1 it reads a status byte, or writes a command.

The peripheral side has two handshakes:
- **Strobe (input).** A falling edge on the active-low strobe loads the port pins into an input latch.
- **Acknowledge (output).** While the active-low acknowledge is held, the output latch is driven onto the pins. At all other times the pins are released.

Two buffer-full flags and two interrupt enables combine into one interrupt request. The status byte shows all of this state. The status byte also carries three general-purpose lines. These lines are usable only while the neighbouring port group is not in its own handshaked mode. A command byte has one of two meanings:
- With bit 7 set, it is a mode word. It sets the direction of the general-purpose lines and the neighbour group's direction and mode.
- With bit 7 clear, it is a single-bit set/reset command.

All inputs are assumed synchronous to `clk`. Reset is asynchronous and active low.

Top module: `duplex_pport`

## Requirements
- R1: After reset the block is in this state:
  - `obf_n` is 1, `ibf` is 0, `irq` is 0 and `pa_oe` is 0.
  - The general-purpose lines are inputs, so `gp_oe` is 000.
  - The status byte reads {obf_n=1, 0, 0, 0, 0, gp_in}.
- R2: A CPU write to address 0 loads the byte into the output latch. From the next cycle `obf_n` is 0, and status bit 7 reads 0.
- R3: While `ack_n` is 0, `pa_oe` is 1 and `pa_out` shows the output latch. While `ack_n` is 1, `pa_oe` is 0.
- R4: A falling edge of `ack_n` (seen at a clock edge) while `obf_n` is 0 returns `obf_n` to 1 on the next cycle.
- R5: A falling edge of `stb_n` loads `pa_in` into the input latch. From the next cycle `ibf` is 1, and status bit 5 reads 1.
- R6: A CPU read of address 0 returns the input latch in the same cycle, and `ibf` is 0 from the next cycle. If a strobe edge falls in the same cycle as the read, the capture wins: `ibf` stays 1 and the latch holds the new byte.
- R7: A command byte with bit 7 = 0 is a set/reset command. Bits 3..1 select a target and bit 0 is the new value:
  - Target 6 is the output interrupt enable (status bit 6).
  - Target 4 is the input interrupt enable (status bit 4).
  - Targets 2..0 are the general-purpose output latch bits.
  - Targets 7, 5 and 3 change nothing.
- R8: `irq` (also status bit 3) is 1 when either of these holds:
  - The input enable is set and `ibf` is 1.
  - The output enable is set and an output-done event is pending.

  The pending event is set when an acknowledge edge empties the buffer. It is cleared by the next CPU write to address 0.
- R9: A command byte with bit 7 = 1 is a mode word:
  - Bit 0 sets the general-purpose direction (1 = input, 0 = output).
  - Bit 1 drives `peer_dir_in`.
  - Bit 2 drives `peer_hs_mode`.

  While `peer_hs_mode` is 1, `gp_oe` is 000 and status bits 2..0 read 000. Otherwise status bits 2..0 show `gp_in` for input lines and the latch for output lines.
- R10: If a CPU data write and a falling `ack_n` edge land in the same cycle, the write wins. `obf_n` is 0 afterwards, and no output-done event is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 1 | 0 = data register, 1 = status/command register |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from address |
| pa_in | input | 8 | Port pins as seen from outside |
| pa_out | output | 8 | Output latch value for the pins |
| pa_oe | output | 1 | Pin drive enable |
| stb_n | input | 1 | Peripheral input strobe, active low |
| ack_n | input | 1 | Peripheral output acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| irq | output | 1 | Interrupt request |
| gp_in | input | 3 | General-purpose line pin values |
| gp_out | output | 3 | General-purpose output latch |
| gp_oe | output | 3 | General-purpose drive enables |
| peer_dir_in | output | 1 | Neighbour port direction, 1 = input |
| peer_hs_mode | output | 1 | Neighbour group is in handshaked mode |

## Verification
The output path is tried in three ways:
- a plain write followed by an acknowledge pulse, which separates the drive-enable window from the flag release one edge later;
- a second write while an output-done event is pending, which shows that the request is cleared by servicing and not by the acknowledge;
- a write landing on the acknowledge edge itself, which exposes the wrong priority.

The input path is tried with distinct byte values: a lone strobe, then a read that clears the flag, then a strobe that collides with a read. The distinct values catch a latch that loads at the wrong time or a flag that clears when it should stay set. Set/reset commands go to each live target and to the unused targets. Mode words are tried with and without the neighbour's handshaked mode, which shows whether the general-purpose view switches between pins, latch and zero.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int PDW = 8;
  localparam int GPW = 3;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_INTE_OUT = 3'd6;
  localparam logic [SEL_W-1:0] SEL_INTE_IN  = 3'd4;

  typedef struct packed {
    logic           obf_n;
    logic           inte_out;
    logic           ibf;
    logic           inte_in;
    logic           irq;
    logic [GPW-1:0] gp;
  } status_t;

  function automatic logic is_mode_word(input logic [PDW-1:0] w);
    return w[PDW-1];
  endfunction

  function automatic logic [SEL_W-1:0] bsr_target(input logic [PDW-1:0] w);
    return w[SEL_W:1];
  endfunction

  function automatic logic irq_calc(input logic inte_in, input logic ibf,
                                    input logic inte_out, input logic out_pend);
    return (inte_in & ibf) | (inte_out & out_pend);
  endfunction

  function automatic logic [GPW-1:0] gp_view(input logic dir_in, input logic peer_hs,
                                             input logic [GPW-1:0] pins,
                                             input logic [GPW-1:0] latch);
    if (peer_hs) return '0;
    return dir_in ? pins : latch;
  endfunction
endpackage

// File: rtl/pport_in_side.sv
module pport_in_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_n,
  input  logic [DW-1:0] pins_in,
  input  logic          rd_take,
  output logic [DW-1:0] in_data,
  output logic          ibf,
  output logic          stb_fall
);
  logic stb_q;

  assign stb_fall = stb_q & ~stb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b1;
      in_data <= '0;
      ibf     <= 1'b0;
    end else begin
      stb_q <= stb_n;
      if (stb_fall) begin
        in_data <= pins_in;
        ibf     <= 1'b1;
      end else if (rd_take) begin
        ibf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pport_out_side.sv
module pport_out_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_data,
  output logic          obf_n,
  output logic          out_pend,
  output logic          ack_fall,
  output logic          drive_en
);
  logic ack_q;

  assign ack_fall = ack_q & ~ack_n;
  assign drive_en = ~ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b1;
      out_data <= '0;
      obf_n    <= 1'b1;
      out_pend <= 1'b0;
    end else begin
      ack_q <= ack_n;
      if (wr_en) begin
        out_data <= wdata;
        obf_n    <= 1'b0;
        out_pend <= 1'b0;
      end else if (ack_fall && !obf_n) begin
        obf_n    <= 1'b1;
        out_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int NGP = GPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_wr,
  input  logic [PDW-1:0] cmd_byte,
  output logic           inte_out,
  output logic           inte_in,
  output logic [NGP-1:0] gp_latch,
  output logic           gp_dir_in,
  output logic           peer_dir_in,
  output logic           peer_hs
);
  logic [SEL_W-1:0] tgt;
  logic             unused_cmd;

  assign tgt        = bsr_target(cmd_byte);
  assign unused_cmd = ^cmd_byte[PDW-2:SEL_W+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inte_out    <= 1'b0;
      inte_in     <= 1'b0;
      gp_dir_in   <= 1'b1;
      peer_dir_in <= 1'b1;
      peer_hs     <= 1'b0;
    end else if (cmd_wr) begin
      if (is_mode_word(cmd_byte)) begin
        gp_dir_in   <= cmd_byte[0];
        peer_dir_in <= cmd_byte[1];
        peer_hs     <= cmd_byte[2];
      end else begin
        if (tgt == SEL_INTE_OUT) inte_out <= cmd_byte[0];
        if (tgt == SEL_INTE_IN)  inte_in  <= cmd_byte[0];
      end
    end
  end

  for (genvar g = 0; g < NGP; g++) begin : g_gp_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        gp_latch[g] <= 1'b0;
      else if (cmd_wr && !is_mode_word(cmd_byte) && tgt == SEL_W'(g))
        gp_latch[g] <= cmd_byte[0];
    end
  end
endmodule

// File: rtl/duplex_pport.sv
module duplex_pport
  import pport_pkg::*;
#(
  parameter int DW  = PDW,
  parameter int NGP = GPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_addr,
  input  logic           cpu_rd,
  input  logic           cpu_wr,
  input  logic [DW-1:0]  cpu_wdata,
  output logic [DW-1:0]  cpu_rdata,
  input  logic [DW-1:0]  pa_in,
  output logic [DW-1:0]  pa_out,
  output logic           pa_oe,
  input  logic           stb_n,
  input  logic           ack_n,
  output logic           obf_n,
  output logic           ibf,
  output logic           irq,
  input  logic [NGP-1:0] gp_in,
  output logic [NGP-1:0] gp_out,
  output logic [NGP-1:0] gp_oe,
  output logic           peer_dir_in,
  output logic           peer_hs_mode
);
  // named internal events
  logic data_wr, data_rd, cmd_wr;
  logic stb_fall, ack_fall, out_pend;
  logic inte_in, inte_out, gp_dir_in;
  logic [DW-1:0] in_data;
  status_t st;

  assign data_wr = cpu_wr & ~cpu_addr;
  assign cmd_wr  = cpu_wr &  cpu_addr;
  assign data_rd = cpu_rd & ~cpu_addr;

  pport_in_side #(.DW(DW)) u_in (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .pins_in(pa_in),
    .rd_take(data_rd), .in_data(in_data), .ibf(ibf), .stb_fall(stb_fall)
  );

  pport_out_side #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .wr_en(data_wr),
    .wdata(cpu_wdata), .out_data(pa_out), .obf_n(obf_n),
    .out_pend(out_pend), .ack_fall(ack_fall), .drive_en(pa_oe)
  );

  pport_ctrl #(.NGP(NGP)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cpu_wdata),
    .inte_out(inte_out), .inte_in(inte_in), .gp_latch(gp_out),
    .gp_dir_in(gp_dir_in), .peer_dir_in(peer_dir_in), .peer_hs(peer_hs_mode)
  );

  for (genvar g = 0; g < NGP; g++) begin : g_gp_oe
    assign gp_oe[g] = ~gp_dir_in & ~peer_hs_mode;
  end

  assign irq = irq_calc(inte_in, ibf, inte_out, out_pend);

  always_comb begin
    st          = '0;
    st.obf_n    = obf_n;
    st.inte_out = inte_out;
    st.ibf      = ibf;
    st.inte_in  = inte_in;
    st.irq      = irq;
    st.gp       = gp_view(gp_dir_in, peer_hs_mode, gp_in, gp_out);
  end

  assign cpu_rdata = cpu_addr ? st : in_data;
endmodule

// File: rtl/pport_checker.sv
module pport_checker #(
  parameter int NGP = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           data_wr,
  input logic           data_rd,
  input logic           cmd_wr,
  input logic [7:0]     cpu_wdata,
  input logic           stb_fall,
  input logic           ack_fall,
  input logic           ack_n,
  input logic           pa_oe,
  input logic           obf_n,
  input logic           ibf,
  input logic           irq,
  input logic           inte_in,
  input logic           inte_out,
  input logic           peer_hs_mode,
  input logic [NGP-1:0] gp_oe
);
  assert_obf_low_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !obf_n);

  assert_drive_while_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> pa_oe);

  assert_obf_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !obf_n && !data_wr) |=> obf_n);

  assert_ibf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb_fall |=> ibf);

  assert_ibf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !stb_fall) |=> !ibf);

  assert_inte_in_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cpu_wdata == 8'h09) |=> inte_in);

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((inte_in && ibf) || inte_out));

  assert_out_irq_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fall && !obf_n && !data_wr && inte_out && !(cmd_wr && !cpu_wdata[7])) |=> irq);

  assert_gp_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    peer_hs_mode |-> (gp_oe == '0));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ack_fall) |=> !obf_n);
endmodule

bind duplex_pport pport_checker #(.NGP(NGP)) u_pport_chk (
  .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_rd(data_rd),
  .cmd_wr(cmd_wr), .cpu_wdata(cpu_wdata), .stb_fall(stb_fall),
  .ack_fall(ack_fall), .ack_n(ack_n), .pa_oe(pa_oe), .obf_n(obf_n),
  .ibf(ibf), .irq(irq), .inte_in(inte_in), .inte_out(inte_out),
  .peer_hs_mode(peer_hs_mode), .gp_oe(gp_oe)
);

// File: tb/test_duplex_pport.sv
module test_duplex_pport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_addr = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata, pa_in = '0, pa_out;
  logic       pa_oe, stb_n = 1'b1, ack_n = 1'b1, obf_n, ibf, irq;
  logic [2:0] gp_in = 3'b101, gp_out, gp_oe;
  logic       peer_dir_in, peer_hs_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #2.5 clk = ~clk;

  duplex_pport i_duplex_pport (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .stb_n(stb_n),
    .ack_n(ack_n), .obf_n(obf_n), .ibf(ibf), .irq(irq), .gp_in(gp_in),
    .gp_out(gp_out), .gp_oe(gp_oe), .peer_dir_in(peer_dir_in),
    .peer_hs_mode(peer_hs_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data in the middle of a read cycle
  always @(negedge clk) begin
    if (rst_n && cpu_rd) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual=%0h expected=<none>", cpu_rdata);
      end else begin
        check(req_q.pop_front(), {24'd0, cpu_rdata}, {24'd0, exp_q.pop_front()});
      end
    end
  end

  task automatic cpu_write(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic a, input logic [7:0] exp, input string req);
    @(posedge clk); #1;
    cpu_addr = a; cpu_rd = 1'b1;
    exp_q.push_back(exp); req_q.push_back(req);
    @(posedge clk); #1;
    cpu_rd = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] v);
    @(posedge clk); #1;
    pa_in = v; stb_n = 1'b0;
    @(posedge clk); #1;
    stb_n = 1'b1;
  endtask

  task automatic ack_pulse();
    @(posedge clk); #1;
    ack_n = 1'b0;
    @(posedge clk); #1;
    ack_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 obf_n", obf_n, 1); check("R1 ibf", ibf, 0);
    check("R1 irq", irq, 0); check("R1 pa_oe", pa_oe, 0);
    check("R1 gp_oe", gp_oe, 3'b000);
    cpu_read(1'b1, 8'h85, "R1 status");

    cpu_write(1'b0, 8'hA5);
    @(negedge clk); check("R2 obf_n", obf_n, 0);
    cpu_read(1'b1, 8'h05, "R2 status");

    @(posedge clk); #1 ack_n = 1'b0;
    @(negedge clk);
    check("R3 pa_oe", pa_oe, 1); check("R3 pa_out", pa_out, 8'hA5);
    check("R4 obf_n before edge", obf_n, 0);
    @(negedge clk);
    check("R4 obf_n", obf_n, 1); check("R8 irq disabled", irq, 0);
    @(posedge clk); #1 ack_n = 1'b1;
    @(negedge clk); check("R3 released", pa_oe, 0);

    strobe(8'h3C);
    @(negedge clk); check("R5 ibf", ibf, 1); check("R8 irq disabled in", irq, 0);
    cpu_read(1'b1, 8'hA5, "R5 status");
    cpu_read(1'b0, 8'h3C, "R6 data");
    @(negedge clk); check("R6 ibf cleared", ibf, 0);

    cpu_write(1'b1, 8'h09);
    cpu_read(1'b1, 8'h95, "R7 inte_in");
    strobe(8'h5A);
    @(negedge clk); check("R8 irq input", irq, 1);
    cpu_read(1'b1, 8'hBD, "R8 status");
    cpu_read(1'b0, 8'h5A, "R8 data");
    @(negedge clk); check("R8 irq cleared by read", irq, 0);

    cpu_write(1'b1, 8'h0D);
    cpu_write(1'b0, 8'h11);
    @(negedge clk); check("R8 irq full", irq, 0);
    ack_pulse();
    @(negedge clk); check("R4 obf_n", obf_n, 1); check("R8 irq output", irq, 1);
    cpu_read(1'b1, 8'hDD, "R8 status out");
    cpu_write(1'b0, 8'h22);
    @(negedge clk); check("R8 irq cleared by write", irq, 0); check("R2 obf_n", obf_n, 0);

    cpu_read(1'b1, 8'h55, "R7 before");
    cpu_write(1'b1, 8'h0F);
    cpu_read(1'b1, 8'h55, "R7 target7 ignored");
    cpu_write(1'b1, 8'h0B);
    cpu_read(1'b1, 8'h55, "R7 target5 ignored");

    cpu_write(1'b1, 8'h80);
    @(negedge clk); check("R9 gp_oe", gp_oe, 3'b111); check("R9 peer_dir", peer_dir_in, 0);
    cpu_read(1'b1, 8'h50, "R9 status out");
    cpu_write(1'b1, 8'h03);
    @(negedge clk); check("R7 gp_out", gp_out, 3'b010);
    cpu_read(1'b1, 8'h52, "R9 status latch");
    cpu_write(1'b1, 8'h86);
    @(negedge clk);
    check("R9 gp_oe off", gp_oe, 3'b000); check("R9 peer_dir", peer_dir_in, 1);
    check("R9 peer_hs", peer_hs_mode, 1);
    cpu_read(1'b1, 8'h50, "R9 status hs");

    @(posedge clk); #1;
    ack_n = 1'b0; cpu_addr = 1'b0; cpu_wdata = 8'h33; cpu_wr = 1'b1;
    @(posedge clk); #1 cpu_wr = 1'b0;
    @(negedge clk);
    check("R10 obf_n", obf_n, 0); check("R10 irq", irq, 0); check("R10 pa_out", pa_out, 8'h33);
    @(posedge clk); #1 ack_n = 1'b1;
    ack_pulse();
    @(negedge clk); check("R4 obf_n", obf_n, 1); check("R8 irq output", irq, 1);
    cpu_write(1'b0, 8'h44);

    strobe(8'h77);
    @(negedge clk); check("R5 ibf", ibf, 1);
    @(posedge clk); #1;
    cpu_addr = 1'b0; cpu_rd = 1'b1; exp_q.push_back(8'h77); req_q.push_back("R6 collide read");
    pa_in = 8'h88; stb_n = 1'b0;
    @(posedge clk); #1 cpu_rd = 1'b0; stb_n = 1'b1;
    @(negedge clk); check("R6 ibf kept", ibf, 1);
    cpu_read(1'b0, 8'h88, "R6 new data");
    @(negedge clk); check("R6 ibf cleared", ibf, 0);

    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule